// File: doc/BRIEF.md
# Slow Clock Ratio Detector

This block watches a free-running sampling clock from the bus clock domain and reports when it has become too slow. The sampling clock is only ever treated as data: it passes through a flop-chain synchronizer, and each synchronized rising edge restarts a saturating count of bus-clock cycles. When that count reaches the ratio limit (32 by default) before the next edge arrives, the sampling clock is running slower than one thirty-second of the bus clock and a live error level is raised.

The live error is not sticky. It falls again on the first synchronized edge that arrives inside the window, so a clock that recovers clears the error without any action from outside. A one-cycle pulse marks every 0-to-1 transition of the live level; a surrounding status block uses it to set its own sticky flag, which this block never clears. A disable input forces the live level low and holds the gap count at zero while it is high.

Top module: `slow_clk_monitor`

## Requirements
- R1: While `rst_n` is 0 and in the cycle after it is released, `err_live` and `err_rise` are 0.
- R2: When synchronized rising edges of `samp_clk` are at most 32 bus-clock cycles apart, `err_live` stays 0.
- R3: When 33 or more bus-clock cycles pass after a synchronized edge with no further edge (including a stopped `samp_clk`), `err_live` becomes 1 and stays 1 until cleared by R4 or R5.
- R4: With `err_live` at 1, the first synchronized edge arriving less than 33 cycles after the previous one sets `err_live` to 0 in the next cycle; a late edge leaves it at 1.
- R5: While `det_off` is 1, `err_live` is 0 from the next cycle on and the gap count restarts, so after `det_off` returns to 0 a stopped clock takes the full 33-cycle window again before `err_live` rises.
- R6: `err_rise` is 1 for exactly one cycle, the first cycle in which `err_live` is 1 after having been 0, and is 0 in every other cycle.
- R7: A steady `samp_clk` period of exactly 32 bus-clock cycles produces no error, while a steady period of 33 bus-clock cycles does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_clk | input | 1 | Sampling clock under observation, asynchronous to `bus_clk` |
| det_off | input | 1 | 1 disables detection and forces `err_live` low |
| err_live | output | 1 | 1 while the sampling clock is judged too slow |
| err_rise | output | 1 | One-cycle pulse on each rise of `err_live` |

## Verification
The trip condition and the clearing edge can fall in the same cycle: a sampling period of exactly 33 cycles makes the edge arrive just as the count reaches the limit, and the error must then stay set rather than clear. A second collision is `det_off` rising in the cycle the count saturates; the bench drops `det_off` onto a stopped clock and expects the forced clear to win. Both are judged by a behavioural model that counts cycles since the last synchronized edge with an unbounded integer and is compared with the outputs on every clock.

// File: rtl/slowclk_pkg.sv
// Shared constants and helpers for the slow clock ratio detector.
package slowclk_pkg;

    // Default bus-to-sampling clock ratio at which the error trips.
    localparam int unsigned DEF_RATIO = 32;

    // Default synchronizer depth (flops before edge detection).
    localparam int unsigned DEF_SYNC = 2;

    // Bits needed to hold a count from 0 up to and including lim.
    function automatic int unsigned cnt_bits(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/slowclk_edge_sync.sv
// Brings the asynchronous sampling clock into the bus domain through a
// flop chain of SYNC_STAGES and flags each synchronized rising edge.
// Assumes samp_clk high and low phases each last longer than a bus cycle
// for every edge to be seen; shorter phases simply look like a slow clock.
module slowclk_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic rst_n,
    input  logic samp_clk,
    output logic rise_o
);
    localparam int unsigned CHAIN = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [CHAIN-1:0] chain_q;
    logic             last_q;

    // Synchronizer chain: stage 0 captures the raw input.
    generate
        for (genvar g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge bus_clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= samp_clk;
                end
            end else begin : g_next
                always_ff @(posedge bus_clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[CHAIN-1];
    end

    // A rising edge is a 1 now that was 0 one cycle ago.
    always_comb rise_o = chain_q[CHAIN-1] & ~last_q;

    // R6-related: an edge cannot repeat on consecutive cycles.
    a_r2_edge_spaced: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/slowclk_gap_cnt.sv
// Counts bus cycles since the last synchronized edge, saturating at LIMIT.
// Cleared by an edge or while detection is disabled. Reports when full.
module slowclk_gap_cnt #(
    parameter int unsigned LIMIT = 32
) (
    input  logic bus_clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic full_o
);
    localparam int unsigned W = slowclk_pkg::cnt_bits(LIMIT);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_q;

    // Saturating gap count, restarted by clr_i.
    always_ff @(posedge bus_clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr_i)        cnt_q <= '0;
        else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    // Full once LIMIT cycles have elapsed without a clear.
    always_comb full_o = (cnt_q == TOP);

    a_r3_cnt_bounded: assert property (@(posedge bus_clk) disable iff (!rst_n)
        cnt_q <= TOP);
    a_r5_cnt_restarts: assert property (@(posedge bus_clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    a_r3_cnt_holds_full: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (full_o && !clr_i) |=> full_o);

endmodule

// File: rtl/slowclk_err_flag.sv
// Holds the live error level and produces a one-cycle pulse on its rise.
// Sets when the gap count is full, clears on a timely edge, forced low
// while disabled. A late edge (count already full) does not clear.
module slowclk_err_flag (
    input  logic bus_clk,
    input  logic rst_n,
    input  logic det_off,
    input  logic edge_i,
    input  logic full_i,
    output logic err_o,
    output logic rise_o
);
    logic err_q;
    logic prev_q;

    // Live error level: disable wins, then trip, then timely-edge clear.
    always_ff @(posedge bus_clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (det_off) err_q <= 1'b0;
        else if (full_i)  err_q <= 1'b1;
        else if (edge_i)  err_q <= 1'b0;
    end

    // Previous level for rise detection.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= err_q;
    end

    // Pulse in the first cycle of a high level.
    always_comb rise_o = err_q & ~prev_q;
    always_comb err_o  = err_q;

    a_r5_off_forces_low: assert property (@(posedge bus_clk) disable iff (!rst_n)
        det_off |=> !err_o);
    a_r3_trip: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (full_i && !det_off) |=> err_o);
    a_r4_timely_clear: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (edge_i && !full_i) |=> !err_o);
    a_r6_pulse_single: assert property (@(posedge bus_clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/slow_clk_monitor.sv
// Top of the slow clock ratio detector. Raises err_live while the
// synchronized sampling clock leaves more than RATIO bus cycles between
// rising edges, and pulses err_rise when that level goes high.
// Assumes rst_n is synchronous to bus_clk.
module slow_clk_monitor #(
    parameter int unsigned RATIO       = slowclk_pkg::DEF_RATIO,
    parameter int unsigned SYNC_STAGES = slowclk_pkg::DEF_SYNC
) (
    input  logic bus_clk,
    input  logic rst_n,
    input  logic samp_clk,
    input  logic det_off,
    output logic err_live,
    output logic err_rise
);
    logic edge_w;
    logic full_w;
    logic clr_w;

    // Counter restarts on an edge or while detection is off.
    always_comb clr_w = edge_w | det_off;

    slowclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .bus_clk (bus_clk),
        .rst_n   (rst_n),
        .samp_clk(samp_clk),
        .rise_o  (edge_w)
    );

    slowclk_gap_cnt #(.LIMIT(RATIO)) u_cnt (
        .bus_clk(bus_clk),
        .rst_n  (rst_n),
        .clr_i  (clr_w),
        .full_o (full_w)
    );

    slowclk_err_flag u_flag (
        .bus_clk(bus_clk),
        .rst_n  (rst_n),
        .det_off(det_off),
        .edge_i (edge_w),
        .full_i (full_w),
        .err_o  (err_live),
        .rise_o (err_rise)
    );

    a_r1_reset_quiet: assert property (@(posedge bus_clk)
        !rst_n |=> (!err_live && !err_rise));

endmodule

// File: tb/slow_clk_monitor_tb.sv
// Bench: behavioural model (sample history queue + unbounded gap integer)
// compared with the outputs on every clock, plus targeted scenario checks.
module slow_clk_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RATIO = 32;
    localparam int WATCHDOG = 150000;

    logic bus_clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_clk = 1'b0;
    logic det_off = 1'b0;
    logic err_live, err_rise;

    int total = 0;
    int bad = 0;
    int rises_seen = 0;
    int cyc = 0;
    bit done = 1'b0;
    string phase = "R1";

    // Model state
    bit hist[$];
    int since = 0;
    bit m_err = 1'b0;
    bit m_prev = 1'b0;
    bit m_rise = 1'b0;

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;

    slow_clk_monitor dut_i (
        .bus_clk(bus_clk), .rst_n(rst_n), .samp_clk(samp_clk),
        .det_off(det_off), .err_live(err_live), .err_rise(err_rise)
    );

    task automatic check(input string req, input bit act, input bit exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: edge seen after two-stage sync plus one compare stage.
    always @(posedge bus_clk) begin
        bit e;
        cyc++;
        if (!rst_n) begin
            hist = '{0, 0, 0};
            since = 0; m_err = 0; m_prev = 0;
        end else begin
            e = hist[1] && !hist[2];
            m_prev = m_err;
            if (det_off)            m_err = 0;
            else if (since >= RATIO) m_err = 1;
            else if (e)              m_err = 0;
            since = (det_off || e) ? 0 : since + 1;
            hist.push_front(samp_clk);
            void'(hist.pop_back());
        end
        m_rise = m_err && !m_prev;
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge bus_clk) begin
        if (rst_n && !done) begin
            check(phase, err_live, m_err, "err_live vs model");
            check("R6", err_rise, m_rise, "err_rise vs model");
            if (err_rise) rises_seen++;
        end
    end

    task automatic run_period(input int lo, input int hi, input int periods);
        for (int p = 0; p < periods; p++) begin
            repeat (lo) @(negedge bus_clk);
            samp_clk = 1'b1;
            repeat (hi) @(negedge bus_clk);
            samp_clk = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > WATCHDOG);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge bus_clk);
        check("R1", err_live, 1'b0, "err_live in reset");
        check("R1", err_rise, 1'b0, "err_rise in reset");
        rst_n = 1'b1;
        @(negedge bus_clk);
        check("R1", err_live, 1'b0, "err_live after reset");
        // R2: fast clock
        phase = "R2";
        run_period(4, 4, 30);
        run_period(10, 12, 20);
        check("R2", err_live, 1'b0, "fast clock");
        // R7: period 32 exactly
        phase = "R7";
        run_period(16, 16, 12);
        check("R7", err_live, 1'b0, "period 32");
        // R7/R3: period 33 (late edge collides with trip)
        run_period(16, 17, 12);
        check("R7", err_live, 1'b1, "period 33");
        check("R6", (rises_seen == 1), 1'b1, "one rise after period 33");
        // R4: recovery
        phase = "R4";
        run_period(8, 8, 4);
        check("R4", err_live, 1'b0, "recovered");
        // R3: stopped clock
        phase = "R3";
        samp_clk = 1'b0;
        repeat (100) @(negedge bus_clk);
        check("R3", err_live, 1'b1, "stopped clock");
        check("R6", (rises_seen == 2), 1'b1, "second rise");
        // R5: disable forces low
        phase = "R5";
        det_off = 1'b1;
        @(negedge bus_clk);
        @(negedge bus_clk);
        check("R5", err_live, 1'b0, "disabled");
        repeat (50) @(negedge bus_clk);
        check("R5", err_live, 1'b0, "still disabled");
        det_off = 1'b0;
        repeat (30) @(negedge bus_clk);
        check("R5", err_live, 1'b0, "window restarts after enable");
        repeat (10) @(negedge bus_clk);
        check("R5", err_live, 1'b1, "trips after full window");
        check("R6", (rises_seen == 3), 1'b1, "third rise");
        // R4: clear after stop
        phase = "R4";
        run_period(6, 6, 6);
        check("R4", err_live, 1'b0, "cleared by fast edges");
        phase = "R2";
        repeat (20) @(negedge bus_clk);
        finish_run();
    end

endmodule